// File: doc/BRIEF.md
# Receive Status and Data Flag Register Bank

This block sits between the bit-level receiver of a serial port and a processor register interface. Each time the receive shifter finishes a frame, it pulses a strobe with the assembled byte and three quality results: noise seen on the line, a low stop bit, and a parity mismatch. The block keeps the byte in a data register and records the event in five sticky flags: data-available, lost-byte (overrun), noise, framing error and parity error.

Software clears a flag with two reads. It reads the status register while the flag is set, which arms that flag. It then reads the data register, which clears every armed flag. Each flag is armed on its own. A flag that rises between the two reads stays set through the data read and shows on the next status read. Software uses this to find out which byte was dropped. When a frame completes while the previous byte is still unread, that frame is discarded, together with its error results.

Each flag, gated by its enable bit, drives a registered interrupt level.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, the status byte, the data byte and all five interrupt outputs are 0.
- R2: A frame strobe is accepted when the data-available flag is clear, or when it is being cleared in the same cycle. On the next clock edge the data output holds the frame byte and status bit 5 (data-available) is 1.
- R3: A frame strobe that arrives while data-available is set and not being cleared is discarded. On the next edge status bit 3 (overrun) is 1 and the data output keeps the older byte.
- R4: An accepted frame sets status bit 2 if it carries noise, bit 1 if it carries a framing error, and bit 0 if it carries a parity error. A discarded frame sets none of these bits.
- R5: Status bits 7, 6 and 4 always read 0.
- R6: A data read clears a flag only if a status read that saw the flag set came earlier. Without any data read, no flag ever clears.
- R7: A flag that sets after the status read and before the data read is not cleared by that data read.
- R8: A data read with no status read before it leaves every flag unchanged.
- R9: Each interrupt output equals its flag ANDed with its enable bit, one clock later. Interrupt and enable bit order is [4] data-available, [3] overrun, [2] noise, [1] framing, [0] parity.
- R10: After a data read that followed an overrun caught late, a second status read still shows overrun at 1. The next data read then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid_i | input | 1 | One-cycle strobe: a frame has completed |
| frm_data_i | input | DW | Byte of the completed frame |
| frm_noise_i | input | 1 | Noise was detected during the frame |
| frm_ferr_i | input | 1 | Stop bit was sampled as 0 |
| frm_perr_i | input | 1 | Parity mismatch |
| stat_rd_i | input | 1 | One-cycle strobe: status register read |
| data_rd_i | input | 1 | One-cycle strobe: data register read |
| irq_en_i | input | 5 | Interrupt enables, order given in R9 |
| stat_o | output | 8 | Status register value |
| data_o | output | DW | Data register value |
| irq_o | output | 5 | Registered interrupt levels |

## Verification
Status and data change on the first clock edge after the strobe that causes them. The interrupt levels change one edge later than the flag they follow. The bench drives each strobe for one cycle starting at a falling edge. It samples status and data at the next falling edge, which comes after exactly one rising edge. For the interrupt checks it first samples at that same point, expecting the old level, and then again one cycle later, expecting the new one. The vector table gives the status and data expected after each step. The directed part covers the reset state, the interrupt delay, the effect of masking, and a frame that arrives in the same cycle as the data read that clears data-available.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int NFLAG   = 5;
  localparam int SW      = 8;
  // internal flag vector positions (match interrupt/enable order)
  localparam int FL_PE   = 0;
  localparam int FL_FE   = 1;
  localparam int FL_NF   = 2;
  localparam int FL_OVR  = 3;
  localparam int FL_FULL = 4;

  function automatic logic [SW-1:0] pack_status(input logic [NFLAG-1:0] f);
    logic [SW-1:0] s;
    s    = '0;
    s[5] = f[FL_FULL];
    s[3] = f[FL_OVR];
    s[2] = f[FL_NF];
    s[1] = f[FL_FE];
    s[0] = f[FL_PE];
    return s;
  endfunction
endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic rd_data_i,
  output logic flag_o,
  output logic clr_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr;

  always_comb begin
    clr    = rd_data_i & arm_q;
    flag_d = set_i | (flag_q & ~clr);
    // arming is lost when the flag is cleared or set again
    arm_d  = ~set_i & ~clr & (arm_q | (rd_stat_i & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign clr_o  = clr;
endmodule

// File: rtl/rxs_data_reg.sv
module rxs_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/rxs_irq_reg.sv
module rxs_irq_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] irq_q, irq_d;

  always_comb irq_d = flags_i & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid_i,
  input  logic [DW-1:0]    frm_data_i,
  input  logic             frm_noise_i,
  input  logic             frm_ferr_i,
  input  logic             frm_perr_i,
  input  logic             stat_rd_i,
  input  logic             data_rd_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [SW-1:0]    stat_o,
  output logic [DW-1:0]    data_o,
  output logic [NFLAG-1:0] irq_o
);
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] clrs;
  logic [NFLAG-1:0] sets;
  logic             accept;

  always_comb begin
    // accepted when empty, or when emptied by this cycle's data read
    accept        = frm_valid_i & (~flags[FL_FULL] | clrs[FL_FULL]);
    sets          = '0;
    sets[FL_FULL] = accept;
    sets[FL_OVR]  = frm_valid_i & ~accept;
    sets[FL_NF]   = accept & frm_noise_i;
    sets[FL_FE]   = accept & frm_ferr_i;
    sets[FL_PE]   = accept & frm_perr_i;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rxs_flag_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (sets[i]),
      .rd_stat_i (stat_rd_i),
      .rd_data_i (data_rd_i),
      .flag_o    (flags[i]),
      .clr_o     (clrs[i])
    );
  end

  rxs_data_reg #(.DW(DW)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .d_i    (frm_data_i),
    .q_o    (data_o)
  );

  rxs_irq_reg #(.N(NFLAG)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  assign stat_o = pack_status(flags);
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid_i,
  input logic [DW-1:0] frm_data_i,
  input logic          data_rd_i,
  input logic [4:0]    irq_en_i,
  input logic [7:0]    stat_o,
  input logic [DW-1:0] data_o,
  input logic [4:0]    irq_o
);
  logic [4:0] fl;
  assign fl = {stat_o[5], stat_o[3], stat_o[2], stat_o[1], stat_o[0]};

  a_r2_accept_latches: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_i && !stat_o[5] |=> stat_o[5] && (data_o == $past(frm_data_i)));

  a_r3_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_i && stat_o[5] && !data_rd_i |=> stat_o[3] && (data_o == $past(data_o)));

  a_r4_discard_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_i && stat_o[5] && !data_rd_i |=> ((stat_o[2:0] & ~$past(stat_o[2:0])) == 3'b000));

  a_r5_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[7:6] == 2'b00) && !stat_o[4]);

  a_r6_no_clear_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  a_r9_irq_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == ($past(fl) & $past(irq_en_i)));
endmodule

bind uart_rx_status rxs_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_valid_i (frm_valid_i),
  .frm_data_i  (frm_data_i),
  .data_rd_i   (data_rd_i),
  .irq_en_i    (irq_en_i),
  .stat_o      (stat_o),
  .data_o      (data_o),
  .irq_o       (irq_o)
);

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  logic       clk;
  logic       rst_n;
  logic       frm_valid_i;
  logic [7:0] frm_data_i;
  logic       frm_noise_i, frm_ferr_i, frm_perr_i;
  logic       stat_rd_i, data_rd_i;
  logic [4:0] irq_en_i;
  logic [7:0] stat_o;
  logic [7:0] data_o;
  logic [4:0] irq_o;

  int checks   = 0;
  int failures = 0;

  uart_rx_status #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid_i), .frm_data_i(frm_data_i),
    .frm_noise_i(frm_noise_i), .frm_ferr_i(frm_ferr_i), .frm_perr_i(frm_perr_i),
    .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i), .irq_en_i(irq_en_i),
    .stat_o(stat_o), .data_o(data_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // op: 0 frame, 1 status read, 2 data read
  // fields {op[1:0], byte[7:0], nfp[2:0], exp_stat[7:0], exp_data[7:0], req[3:0]}
  localparam int NV = 20;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {2'd0, 8'hA5, 3'b000, 8'h20, 8'hA5, 4'd2},
    {2'd1, 8'h00, 3'b000, 8'h20, 8'hA5, 4'd6},
    {2'd2, 8'h00, 3'b000, 8'h00, 8'hA5, 4'd6},
    {2'd0, 8'h3C, 3'b001, 8'h21, 8'h3C, 4'd4},
    {2'd2, 8'h00, 3'b000, 8'h21, 8'h3C, 4'd8},
    {2'd1, 8'h00, 3'b000, 8'h21, 8'h3C, 4'd6},
    {2'd2, 8'h00, 3'b000, 8'h00, 8'h3C, 4'd6},
    {2'd0, 8'h11, 3'b000, 8'h20, 8'h11, 4'd2},
    {2'd0, 8'h22, 3'b010, 8'h28, 8'h11, 4'd3},
    {2'd1, 8'h00, 3'b000, 8'h28, 8'h11, 4'd5},
    {2'd2, 8'h00, 3'b000, 8'h00, 8'h11, 4'd6},
    {2'd0, 8'h33, 3'b100, 8'h24, 8'h33, 4'd4},
    {2'd1, 8'h00, 3'b000, 8'h24, 8'h33, 4'd6},
    {2'd0, 8'h44, 3'b000, 8'h2C, 8'h33, 4'd3},
    {2'd2, 8'h00, 3'b000, 8'h08, 8'h33, 4'd7},
    {2'd1, 8'h00, 3'b000, 8'h08, 8'h33, 4'd10},
    {2'd2, 8'h00, 3'b000, 8'h00, 8'h33, 4'd10},
    {2'd0, 8'h55, 3'b111, 8'h27, 8'h55, 4'd4},
    {2'd1, 8'h00, 3'b000, 8'h27, 8'h55, 4'd5},
    {2'd2, 8'h00, 3'b000, 8'h00, 8'h55, 4'd6}
  };

  function automatic string rq(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    frm_valid_i = 1'b0; frm_data_i = '0;
    frm_noise_i = 1'b0; frm_ferr_i = 1'b0; frm_perr_i = 1'b0;
    stat_rd_i = 1'b0; data_rd_i = 1'b0;
  endtask

  // drive one strobe for one cycle, return at the falling edge after it
  task automatic step(input logic [1:0] op, input logic [7:0] b, input logic [2:0] nfp);
    @(negedge clk);
    frm_valid_i = (op == 2'd0);
    frm_data_i  = b;
    {frm_noise_i, frm_ferr_i, frm_perr_i} = nfp;
    stat_rd_i   = (op == 2'd1);
    data_rd_i   = (op == 2'd2);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    irq_en_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "stat", stat_o, 8'h00);
    check("R1", "data", data_o, 8'h00);
    check("R1", "irq",  irq_o,  5'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][32:31], VEC[i][30:23], VEC[i][22:20]);
      check(rq(int'(VEC[i][3:0])), "stat", stat_o, VEC[i][19:12]);
      check(rq(int'(VEC[i][3:0])), "data", data_o, VEC[i][11:4]);
      check("R5", "spare", stat_o & 8'hD0, 0);
    end

    // R2: frame accepted in the same cycle as the clearing data read
    step(2'd0, 8'h66, 3'b000);
    step(2'd1, 8'h00, 3'b000);
    @(negedge clk);
    frm_valid_i = 1'b1; frm_data_i = 8'h77; data_rd_i = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R2", "same-cycle stat", stat_o, 8'h20);
    check("R2", "same-cycle data", data_o, 8'h77);
    step(2'd1, 8'h00, 3'b000);
    step(2'd2, 8'h00, 3'b000);
    check("R6", "emptied", stat_o, 8'h00);

    // R9 interrupt timing and masking
    irq_en_i = 5'b11111;
    step(2'd0, 8'h88, 3'b010);
    check("R9", "irq before delay", irq_o, 5'b00000);
    @(negedge clk);
    check("R9", "irq after delay", irq_o, 5'b10010);
    irq_en_i = 5'b00010;
    @(negedge clk);
    check("R9", "irq masked", irq_o, 5'b00010);
    irq_en_i = 5'b00000;
    @(negedge clk);
    check("R9", "irq all masked", irq_o, 5'b00000);

    // R1 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "stat after reset", stat_o, 8'h00);
    check("R1", "data after reset", data_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule